// File: doc/BRIEF.md
# Dual-Channel Serial Code Loader

This block is the digital front end of a two-channel 12-bit converter. A host sends one 24-bit frame over a three-wire serial port: a serial clock, a data line and an active-low select. One frame carries the codes for both channels. Each channel then takes its half of the frame into its own holding register when that channel's active-low update strobe is asserted. The two strobes can be asserted one at a time or together. The two held codes drive the converter ladders. An active-low clear zeroes all storage at once.

All pins are sampled by a synchronous system clock that runs at least eight times faster than the serial clock. Each pin passes through a two-flop synchroniser, and serial-clock edges are detected inside the block. Clear takes effect asynchronously and is released in step with the system clock. Frame length is not policed: whatever the last 24 shifted bits are, those are the frame.

Top module: `dual_code_loader`

## Requirements
- R1: While select is low, each falling edge of the serial clock shifts the sampled data bit into bit 23 of the 24-bit input register, and each older bit moves one place toward bit 0.
- R2: While select is high, serial clock edges leave the input register unchanged.
- R3: Channel A's code is input-register bits 12 to 23, with bit 12 as its MSB and bit 23 as its LSB. For a frame sent as word W most-significant bit first, code_a equals W[11:0].
- R4: Channel B's code is input-register bits 0 to 11, with bit 0 as its MSB. The first bit sent becomes B's MSB, so for word W, code_b equals W[23:12].
- R5: With select low, update A low and update B high, only channel A's holding register loads. code_b keeps its value.
- R6: With select low, update B low and update A high, only channel B's holding register loads. code_a keeps its value.
- R7: With select low and both update strobes low, both holding registers load from the same frame.
- R8: Clear low zeroes the input register and both holding registers at once, without waiting for a clock edge, whatever the other inputs are doing.
- R9: While select is high, the update strobes have no effect on either output.
- R10: A frame longer than 24 serial clocks is not rejected. The last 24 bits shifted in are the ones loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| clr_n | input | 1 | Active-low clear, asynchronous assert |
| sclk | input | 1 | Serial clock, data taken on its falling edge |
| sdin | input | 1 | Serial data |
| cs_n | input | 1 | Active-low select |
| upd_a_n | input | 1 | Active-low channel A update strobe |
| upd_b_n | input | 1 | Active-low channel B update strobe |
| code_a | output | 12 | Channel A held code |
| code_b | output | 12 | Channel B held code |

## Verification
The bench sends random frames and follows each one with a random update pattern: A only, B only, or both. A design that swapped the halves or reversed the bit order inside a field would show mirrored codes. A design that decoded the strobes loosely would change the channel that was meant to stay put. Directed cases toggle the serial clock while select is high and pulse the strobes while select is high, where a design that ignores select would take in stray bits or load a stale frame. Further cases send a 30-bit frame, where a design that counts bits would drop the trailing bits, and drive clear in the middle of operation, where zeroing that was synchronous only, or that missed the input register, would show up at once or on the next update.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  localparam int unsigned DEF_CODE_W = 12;
  localparam int unsigned DEF_NCH    = 2;
  localparam int unsigned PIN_CNT    = 5;
  // pin slots in the synchroniser vector
  localparam int unsigned PIN_SCLK = 0;
  localparam int unsigned PIN_SDIN = 1;
  localparam int unsigned PIN_CS   = 2;
  localparam int unsigned PIN_UPD0 = 3;
  // idle level of each pin at reset: strobes, select and clock high, data low
  localparam logic [PIN_CNT-1:0] PIN_IDLE = 5'b11101;
endpackage

// File: rtl/dcl_reset_sync.sv
module dcl_reset_sync (
  input  logic clk,
  input  logic clr_n,
  output logic rst_n
);
  logic [1:0] chain_q;
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) chain_q <= 2'b00;
    else        chain_q <= {chain_q[0], 1'b1};
  end
  assign rst_n = chain_q[1];
endmodule

// File: rtl/dcl_pin_sync.sv
module dcl_pin_sync #(
  parameter int unsigned N = 5,
  parameter logic [N-1:0] IDLE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] meta_q, sync_q;
  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= IDLE[i];
        sync_q[i] <= IDLE[i];
      end else begin
        meta_q[i] <= pin_i[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end
  assign sync_o = sync_q;
endmodule

// File: rtl/dcl_shift_reg.sv
module dcl_shift_reg #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         sel_high,
  input  logic         din,
  output logic [W-1:0] sr_o
);
  logic [W-1:0] sr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (shift_en) sr_q <= {din, sr_q[W-1:1]};
  end
  assign sr_o = sr_q;

  // R1: an older bit moves one place toward bit 0 on a shift
  assert_shift_moves_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sr_q[W-2] == $past(sr_q[W-1]));
  // R2: select high freezes the register
  assert_sel_high_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_high |=> $stable(sr_q));
endmodule

// File: rtl/dcl_hold_reg.sv
module dcl_hold_reg #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [CW-1:0] field_i,
  output logic [CW-1:0] code_o
);
  logic [CW-1:0] ordered;
  logic [CW-1:0] hold_q;
  // lowest register bit of the field is the code MSB
  always_comb begin
    for (int k = 0; k < CW; k++) ordered[k] = field_i[CW-1-k];
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (load_en) hold_q <= ordered;
  end
  assign code_o = hold_q;

  // R5 / R6: a channel whose strobe is not active keeps its code
  assert_idle_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(hold_q));
  // R8: while reset is held the code reads zero
  assert_clear_zero_R8: assert property (@(posedge clk)
    !rst_n |-> hold_q == '0);
endmodule

// File: rtl/dual_code_loader.sv
module dual_code_loader #(
  parameter int unsigned CODE_W = dcl_pkg::DEF_CODE_W,
  parameter int unsigned NCH    = dcl_pkg::DEF_NCH
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              cs_n,
  input  logic              upd_a_n,
  input  logic              upd_b_n,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b
);
  import dcl_pkg::*;
  localparam int unsigned FRAME_W = CODE_W * NCH;

  logic               rst_n;
  logic [PIN_CNT-1:0] pins, pin_q;
  logic               sclk_prev_q;
  logic               sclk_fall, shift_en, sel_high;
  logic [NCH-1:0]     load_en;
  logic [FRAME_W-1:0] frame;
  logic [CODE_W-1:0]  codes [NCH];

  dcl_reset_sync u_rst (.clk(clk), .clr_n(clr_n), .rst_n(rst_n));

  assign pins = {upd_b_n, upd_a_n, cs_n, sdin, sclk};
  dcl_pin_sync #(.N(PIN_CNT), .IDLE(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .sync_o(pin_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b1;
    else        sclk_prev_q <= pin_q[PIN_SCLK];
  end

  assign sclk_fall = sclk_prev_q & ~pin_q[PIN_SCLK];
  assign sel_high  = pin_q[PIN_CS];
  assign shift_en  = sclk_fall & ~sel_high;

  dcl_shift_reg #(.W(FRAME_W)) u_sr (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sel_high(sel_high),
    .din(pin_q[PIN_SDIN]), .sr_o(frame));

  // channel 0 (A) uses the upper field, channel 1 (B) the lower one
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int unsigned BASE = (NCH - 1 - ch) * CODE_W;
    assign load_en[ch] = ~sel_high & ~pin_q[PIN_UPD0 + ch];
    dcl_hold_reg #(.CW(CODE_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .load_en(load_en[ch]),
      .field_i(frame[BASE +: CODE_W]), .code_o(codes[ch]));
  end

  assign code_a = codes[0];
  assign code_b = codes[1];

  // R9: strobes are ignored while select is high
  assert_sel_high_no_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_high |=> ($stable(code_a) && $stable(code_b)));
  // R7: both strobes active means both channels load together
  assert_both_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en == '1) |=> (code_a[CODE_W-1] == $past(frame[FRAME_W-CODE_W]) &&
                         code_b[CODE_W-1] == $past(frame[0])));
endmodule

// File: tb/tb_dual_code_loader.sv
module tb_dual_code_loader;
  logic clk = 1'b0, clr_n = 1'b0, sclk = 1'b1, sdin = 1'b0;
  logic cs_n = 1'b1, upd_a_n = 1'b1, upd_b_n = 1'b1;
  logic [11:0] code_a, code_b;
  logic [11:0] exp_a, exp_b;
  int total = 0, bad = 0;
  bit done = 0;

  dual_code_loader dut (.clk(clk), .clr_n(clr_n), .sclk(sclk), .sdin(sdin),
    .cs_n(cs_n), .upd_a_n(upd_a_n), .upd_b_n(upd_b_n),
    .code_a(code_a), .code_b(code_b));

  always #4 clk = ~clk;

  // bench model: word sent MSB first splits as B = top half, A = bottom half
  function automatic logic [11:0] model_a(logic [23:0] w); return w[11:0]; endfunction
  function automatic logic [11:0] model_b(logic [23:0] w); return w[23:12]; endfunction

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [11:0] got, logic [11:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic shift_bits(logic [63:0] bits, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdin = bits[i]; sclk = 1'b1; waitc(6);
      sclk = 1'b0; waitc(6);
    end
    sclk = 1'b1; waitc(6);
  endtask

  task automatic send_frame(logic [63:0] bits, int n);
    cs_n = 1'b0; waitc(4);
    shift_bits(bits, n);
    cs_n = 1'b1; waitc(6);
  endtask

  task automatic update(bit a, bit b, bit sel);
    cs_n = ~sel; waitc(4);
    upd_a_n = ~a; upd_b_n = ~b; waitc(6);
    upd_a_n = 1'b1; upd_b_n = 1'b1; waitc(4);
    cs_n = 1'b1; waitc(8);
  endtask

  initial begin
    logic [23:0] w;
    int kind;
    void'($urandom(32'h5eed));
    waitc(3);
    chk("R8 reset code_a", code_a, 12'h000);
    chk("R8 reset code_b", code_b, 12'h000);
    clr_n = 1'b1; waitc(6);

    // directed: both channels, distinct halves
    w = 24'hABC123;
    send_frame(64'(w), 24); update(1, 1, 1);
    exp_a = model_a(w); exp_b = model_b(w);
    chk("R3 A field", code_a, exp_a);
    chk("R4 B field first bit MSB", code_b, exp_b);

    // R2: clock toggles with select high change nothing
    shift_bits(64'hFFFFFF, 24);
    update(1, 1, 1);
    chk("R2 sel high no shift A", code_a, exp_a);
    chk("R2 sel high no shift B", code_b, exp_b);

    // R9: strobes with select high are ignored
    send_frame(64'h5A5F0F, 24);
    update(1, 1, 0);
    chk("R9 strobe ignored A", code_a, exp_a);
    chk("R9 strobe ignored B", code_b, exp_b);

    // R10: 30-bit frame, last 24 bits count
    send_frame(64'h2B_5A5_C3C, 30); update(1, 1, 1);
    exp_a = 12'hC3C; exp_b = 12'h5A5;
    chk("R10 long frame A", code_a, exp_a);
    chk("R10 long frame B", code_b, exp_b);

    // random frames with random strobe patterns
    for (int f = 0; f < 40; f++) begin
      w = 24'($urandom);
      kind = int'($urandom % 3);
      send_frame(64'(w), 24);
      if (kind == 0) begin
        update(1, 0, 1); exp_a = model_a(w);
        chk("R5 A only a", code_a, exp_a);
        chk("R5 A only b kept", code_b, exp_b);
      end else if (kind == 1) begin
        update(0, 1, 1); exp_b = model_b(w);
        chk("R6 B only b", code_b, exp_b);
        chk("R6 B only a kept", code_a, exp_a);
      end else begin
        update(1, 1, 1); exp_a = model_a(w); exp_b = model_b(w);
        chk("R7 both a", code_a, exp_a);
        chk("R7 both b", code_b, exp_b);
      end
    end
    // R1: single extra bit after a frame shifts the whole register by one
    w = 24'h800001;
    send_frame(64'(w), 24);
    send_frame(64'h1, 1);
    update(1, 1, 1);
    chk("R1 shift by one A", code_a, model_a({w[22:0], 1'b1}));
    chk("R1 shift by one B", code_b, model_b({w[22:0], 1'b1}));

    // R8: clear mid-operation, asynchronous
    send_frame(64'hFFFFFF, 24);
    cs_n = 1'b0; sclk = 1'b0; waitc(2);
    @(posedge clk); #1 clr_n = 1'b0; #1;
    chk("R8 async clear A", code_a, 12'h000);
    chk("R8 async clear B", code_b, 12'h000);
    waitc(3); cs_n = 1'b1; sclk = 1'b1; waitc(3);
    clr_n = 1'b1; waitc(6);
    update(1, 1, 1);
    chk("R8 input reg cleared A", code_a, 12'h000);
    chk("R8 input reg cleared B", code_b, 12'h000);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog got=hung exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule